// File: doc/BRIEF.md
# Handshaked Byte-Bus Register Slave

This block is the chip-side end of an eight-bit parallel bus that an external microcontroller drives. The host frames each transaction with a start line. It moves one byte at a time with a four-phase handshake: the host raises its strobe and the block answers with its own strobe. All host control lines are asynchronous to the block clock. The block synchronises them before its state machine looks at them.

A transaction carries a fixed six-byte command: an opcode, a register address, and a 32-bit data word sent least significant byte first. The block then returns an eight-byte reply. The reply is the data word followed by a status word, each least significant byte first. The register space is flat and addressed by one byte. Address 0 holds a read-only word that describes the build: the version and how many units of each kind sit behind the bus. Host software uses those counts to work out where each group of unit registers starts. The unit registers are plain 32-bit stub registers here.

Top module: `hbus_reg_slave`

## Requirements
- R1: After reset, `blk_hs2`, `blk_ack` and `blk_data_oe` are 0, and every unit register reads back as 0.
- R2: Holding `host_rst_n` low for several clocks returns the block to its reset state. All unit registers read back 0 afterwards and `blk_ack` is 0.
- R3: With start high, the block raises `blk_hs2` in answer to each `host_hs1` rise.
- R4: `blk_hs2` stays high for as long as `host_hs1` stays high. It falls only after `host_hs1` has fallen.
- R5: The command bytes arrive in this order: opcode, address, then data bits [7:0], [15:8], [23:16], [31:24]. Opcode 0x02 writes the data word to the addressed register. The reply then carries status 0 and word 0 equal to 0.
- R6: Opcode 0x01 reads the addressed register. The reply is 8 bytes: word 0 (the read value), then word 1 (the status), each least significant byte first.
- R7: Address 0 reads {12'b0, servo count[19:16], encoder count[15:12], PWM count[11:8], minor[7:4], major[3:0]}. A write to address 0 returns status 3 and changes nothing.
- R8: PWM registers start at address 1. Encoder registers follow the last PWM register, and servo registers follow the last encoder register. An address past the last servo register returns status 2 and word 0 equal to 0, and writes nothing.
- R9: Any opcode other than 0x01 or 0x02 returns status 1 and word 0 equal to 0, and changes no register.
- R10: `blk_ack` rises once start is seen. It falls on the release of the last reply byte. After the host lowers start, the block accepts a new transaction.
- R11: If start falls before the reply is complete, the block drops `blk_hs2` and `blk_ack`, returns to idle and writes nothing.
- R12: `blk_data_oe` is 1 only while a reply byte is being handshaked with `host_rw` = 0 (read). It is 0 while command bytes are taken with `host_rw` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low chip reset |
| host_rst_n | input | 1 | Asynchronous active-low reset line from the host |
| host_start | input | 1 | Asynchronous transaction frame line |
| host_rw | input | 1 | Asynchronous direction: 1 = host writes, 0 = host reads |
| host_hs1 | input | 1 | Asynchronous host byte strobe |
| host_data_in | input | 8 | Byte presented by the host |
| blk_data_out | output | 8 | Reply byte driven by the block |
| blk_data_oe | output | 1 | Output enable for `blk_data_out` |
| blk_hs2 | output | 1 | Block byte acknowledge strobe |
| blk_ack | output | 1 | Transaction busy flag |

## Verification
The bench builds the block with 4 PWM units of 4 registers, 2 encoder units of 4 registers and 4 servo units of 2 registers, version 1.2. This places the group bases at 1, 17 and 25 and the last mapped address at 32. The first base, each group boundary and the first unmapped address 33 can then all be hit directly, and random addresses fall on both sides of the map. The unit counts each fit their 4-bit field, so the full self-description word 0x00042421 is checked.

// File: rtl/hbus_pkg.sv
// Shared constants and types for the byte-bus register slave.
// Assumes a fixed six-byte command and a two-word reply.
package hbus_pkg;
    localparam int CMD_BYTES = 6;
    localparam int RSP_WORDS = 2;
    localparam int RSP_BYTES = RSP_WORDS * 4;
    localparam int FRAME_W   = CMD_BYTES * 8;
    localparam int RSP_W     = RSP_BYTES * 8;
    localparam int CNT_W     = $clog2(RSP_BYTES);

    localparam logic [7:0] OP_READ  = 8'h01;
    localparam logic [7:0] OP_WRITE = 8'h02;

    localparam logic [7:0] ST_OK        = 8'd0;
    localparam logic [7:0] ST_BAD_OP    = 8'd1;
    localparam logic [7:0] ST_BAD_ADDR  = 8'd2;
    localparam logic [7:0] ST_READ_ONLY = 8'd3;

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CMD_HI,
        PH_CMD_LO,
        PH_EXEC,
        PH_RSP_HI,
        PH_RSP_LO,
        PH_DONE
    } phase_t;
endpackage

// File: rtl/hbus_sync.sv
// Multi-stage synchroniser for a bundle of asynchronous single-bit lines.
// Assumes each bit is independent; reset value of every stage is 0.
module hbus_sync #(
    parameter int WIDTH  = 4,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] pipe [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        // Advance one synchroniser stage per clock.
        always_ff @(posedge clk) begin
            if (!rst_n)
                pipe[s] <= '0;
            else if (s == 0)
                pipe[s] <= d_async;
            else
                pipe[s] <= pipe[(s == 0) ? 0 : s - 1];
        end
    end

    assign q_sync = pipe[STAGES-1];
endmodule

// File: rtl/hbus_regmap.sv
// Register space behind the bus: a read-only description word at address 0
// and flat stub registers for PWM, encoder and servo groups placed back to back.
// Assumes the whole map fits in 256 addresses.
module hbus_regmap
    import hbus_pkg::*;
#(
    parameter int N_PWM     = 4,
    parameter int PWM_REGS  = 4,
    parameter int N_QE      = 2,
    parameter int QE_REGS   = 4,
    parameter int N_RC      = 4,
    parameter int RC_REGS   = 2,
    parameter int VER_MAJOR = 1,
    parameter int VER_MINOR = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        exec,
    input  logic [7:0]  opcode,
    input  logic [7:0]  addr,
    input  logic [31:0] wdata,
    output logic [31:0] word0,
    output logic [7:0]  status,
    output logic        wr_en
);
    localparam int PWM_BASE = 1;
    localparam int QE_BASE  = PWM_BASE + N_PWM * PWM_REGS;
    localparam int RC_BASE  = QE_BASE + N_QE * QE_REGS;
    localparam int END_ADDR = RC_BASE + N_RC * RC_REGS;
    localparam int NUM_STUB = END_ADDR - 1;

    localparam logic [31:0] SYS_WORD = {12'h000, 4'(N_RC), 4'(N_QE), 4'(N_PWM),
                                        4'(VER_MINOR), 4'(VER_MAJOR)};

    logic [31:0] stub [NUM_STUB];
    logic [31:0] rd_val;

    for (genvar g = 0; g < NUM_STUB; g++) begin : g_stub
        logic [31:0] val;
        // Hold one unit register; load it on an accepted write to its address.
        always_ff @(posedge clk) begin
            if (!rst_n)
                val <= '0;
            else if (wr_en && addr == 8'(g + 1))
                val <= wdata;
        end
        assign stub[g] = val;
    end

    // Classify the command: opcode first, then address range, then write protection.
    always_comb begin
        if (opcode != OP_READ && opcode != OP_WRITE)
            status = ST_BAD_OP;
        else if (32'(addr) >= 32'(END_ADDR))
            status = ST_BAD_ADDR;
        else if (opcode == OP_WRITE && addr == 8'd0)
            status = ST_READ_ONLY;
        else
            status = ST_OK;
    end

    // Select the addressed register value.
    always_comb begin
        rd_val = (addr == 8'd0) ? SYS_WORD : 32'd0;
        for (int i = 0; i < NUM_STUB; i++)
            if (addr == 8'(i + 1))
                rd_val = stub[i];
    end

    assign wr_en = exec && status == ST_OK && opcode == OP_WRITE;
    assign word0 = (status == ST_OK && opcode == OP_READ) ? rd_val : 32'd0;
endmodule

// File: rtl/hbus_ctrl.sv
// Handshake state machine: takes the six command bytes, issues one execute
// cycle, then serialises the reply. Assumes start, rw and hs1 are synchronised.
module hbus_ctrl
    import hbus_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start_s,
    input  logic               rw_s,
    input  logic               hs1_s,
    input  logic [7:0]         data_in,
    input  logic [31:0]        word0,
    input  logic [7:0]         status,
    output logic [7:0]         opcode,
    output logic [7:0]         addr,
    output logic [31:0]        wdata,
    output logic               exec,
    output logic               hs2,
    output logic               ack,
    output logic [7:0]         data_out,
    output logic               data_oe
);
    phase_t             phase;
    logic [CNT_W-1:0]   cnt;
    logic [FRAME_W-1:0] frame;
    logic [RSP_W-1:0]   rsp;
    logic [7:0]         data_q;

    // Advance the transaction phase, capture command bytes and shift reply bytes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase  <= PH_IDLE;
            cnt    <= '0;
            frame  <= '0;
            rsp    <= '0;
            data_q <= '0;
            hs2    <= 1'b0;
            ack    <= 1'b0;
        end else begin
            data_q <= data_in;
            if (!start_s && phase != PH_IDLE) begin
                phase <= PH_IDLE;
                hs2   <= 1'b0;
                ack   <= 1'b0;
            end else begin
                unique case (phase)
                    PH_IDLE: if (start_s) begin
                        ack   <= 1'b1;
                        cnt   <= '0;
                        phase <= PH_CMD_HI;
                    end
                    PH_CMD_HI: if (hs1_s) begin
                        frame <= {data_q, frame[FRAME_W-1:8]};
                        hs2   <= 1'b1;
                        phase <= PH_CMD_LO;
                    end
                    PH_CMD_LO: if (!hs1_s) begin
                        hs2 <= 1'b0;
                        if (cnt == CNT_W'(CMD_BYTES - 1)) begin
                            phase <= PH_EXEC;
                        end else begin
                            cnt   <= cnt + 1'b1;
                            phase <= PH_CMD_HI;
                        end
                    end
                    PH_EXEC: begin
                        rsp   <= {24'd0, status, word0};
                        cnt   <= '0;
                        phase <= PH_RSP_HI;
                    end
                    PH_RSP_HI: if (hs1_s) begin
                        hs2   <= 1'b1;
                        phase <= PH_RSP_LO;
                    end
                    PH_RSP_LO: if (!hs1_s) begin
                        hs2 <= 1'b0;
                        rsp <= {8'd0, rsp[RSP_W-1:8]};
                        if (cnt == CNT_W'(RSP_BYTES - 1)) begin
                            ack   <= 1'b0;
                            phase <= PH_DONE;
                        end else begin
                            cnt   <= cnt + 1'b1;
                            phase <= PH_RSP_HI;
                        end
                    end
                    PH_DONE: ;
                    default: phase <= PH_IDLE;
                endcase
            end
        end
    end

    assign opcode   = frame[7:0];
    assign addr     = frame[15:8];
    assign wdata    = frame[47:16];
    assign exec     = phase == PH_EXEC && start_s;
    assign data_out = rsp[7:0];
    assign data_oe  = (phase == PH_RSP_HI || phase == PH_RSP_LO) && !rw_s;
endmodule

// File: rtl/hbus_reg_slave.sv
// Top of the byte-bus register slave: synchronises host lines, folds the host
// reset into the block reset and joins the handshake engine to the register map.
module hbus_reg_slave #(
    parameter int N_PWM     = 4,
    parameter int PWM_REGS  = 4,
    parameter int N_QE      = 2,
    parameter int QE_REGS   = 4,
    parameter int N_RC      = 4,
    parameter int RC_REGS   = 2,
    parameter int VER_MAJOR = 1,
    parameter int VER_MINOR = 2,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       host_rst_n,
    input  logic       host_start,
    input  logic       host_rw,
    input  logic       host_hs1,
    input  logic [7:0] host_data_in,
    output logic [7:0] blk_data_out,
    output logic       blk_data_oe,
    output logic       blk_hs2,
    output logic       blk_ack
);
    logic [3:0]  sync_q;
    logic        hrst_s, start_s, rw_s, hs1_s;
    logic        rst_int_n;
    logic [7:0]  opcode, addr, status;
    logic [31:0] wdata, word0;
    logic        exec, wr_en;

    hbus_sync #(.WIDTH(4), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async ({host_rst_n, host_start, host_rw, host_hs1}),
        .q_sync  (sync_q)
    );

    assign {hrst_s, start_s, rw_s, hs1_s} = sync_q;
    assign rst_int_n = rst_n && hrst_s;

    hbus_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_int_n),
        .start_s  (start_s),
        .rw_s     (rw_s),
        .hs1_s    (hs1_s),
        .data_in  (host_data_in),
        .word0    (word0),
        .status   (status),
        .opcode   (opcode),
        .addr     (addr),
        .wdata    (wdata),
        .exec     (exec),
        .hs2      (blk_hs2),
        .ack      (blk_ack),
        .data_out (blk_data_out),
        .data_oe  (blk_data_oe)
    );

    hbus_regmap #(
        .N_PWM(N_PWM), .PWM_REGS(PWM_REGS), .N_QE(N_QE), .QE_REGS(QE_REGS),
        .N_RC(N_RC), .RC_REGS(RC_REGS), .VER_MAJOR(VER_MAJOR), .VER_MINOR(VER_MINOR)
    ) u_regmap (
        .clk    (clk),
        .rst_n  (rst_int_n),
        .exec   (exec),
        .opcode (opcode),
        .addr   (addr),
        .wdata  (wdata),
        .word0  (word0),
        .status (status),
        .wr_en  (wr_en)
    );
endmodule

// File: rtl/hbus_reg_slave_chk.sv
// Protocol checker for the byte-bus register slave, bound to the top module.
// Assumes END_ADDR matches the register map built from the same parameters.
module hbus_reg_slave_chk #(
    parameter int END_ADDR = 33
) (
    input logic       clk,
    input logic       rst_int_n,
    input logic       start_s,
    input logic       hs1_s,
    input logic       hs2,
    input logic       ack,
    input logic       wr_en,
    input logic [7:0] addr
);
    AST_HS2_ANSWERS_HS1: assert property (@(posedge clk) disable iff (!rst_int_n)
        $rose(hs2) |-> $past(hs1_s) && $past(start_s));                      // R3
    AST_HS2_HOLDS: assert property (@(posedge clk) disable iff (!rst_int_n)
        $fell(hs2) |-> !$past(hs1_s) || !$past(start_s) || !$past(rst_int_n)); // R4
    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (!rst_int_n)
        wr_en |=> !wr_en);                                                    // R5
    AST_WRITE_MAPPED: assert property (@(posedge clk) disable iff (!rst_int_n)
        wr_en |-> addr != 8'd0 && 32'(addr) < 32'(END_ADDR));                 // R8
    AST_HS2_IN_TXN: assert property (@(posedge clk) disable iff (!rst_int_n)
        hs2 |-> ack);                                                         // R10
    AST_START_DROP: assert property (@(posedge clk) disable iff (!rst_int_n)
        !start_s |=> !ack && !hs2);                                           // R11
endmodule

bind hbus_reg_slave hbus_reg_slave_chk #(
    .END_ADDR(1 + N_PWM * PWM_REGS + N_QE * QE_REGS + N_RC * RC_REGS)
) u_chk (
    .clk       (clk),
    .rst_int_n (rst_int_n),
    .start_s   (start_s),
    .hs1_s     (hs1_s),
    .hs2       (blk_hs2),
    .ack       (blk_ack),
    .wr_en     (wr_en),
    .addr      (addr)
);

// File: tb/test_hbus_reg_slave.sv
module test_hbus_reg_slave;
    localparam int N_PWM = 4, PWM_REGS = 4, N_QE = 2, QE_REGS = 4, N_RC = 4, RC_REGS = 2;
    localparam int END_ADDR = 1 + N_PWM * PWM_REGS + N_QE * QE_REGS + N_RC * RC_REGS;
    localparam logic [31:0] SYS_WORD = 32'h0004_2421;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       host_rst_n = 1'b1;
    logic       host_start = 1'b0;
    logic       host_rw = 1'b1;
    logic       host_hs1 = 1'b0;
    logic [7:0] host_data_in = 8'd0;
    logic [7:0] blk_data_out;
    logic       blk_data_oe, blk_hs2, blk_ack;

    int checks = 0;
    int errors = 0;
    logic [31:0] model [256];

    always #4 clk = ~clk;

    hbus_reg_slave #(
        .N_PWM(N_PWM), .PWM_REGS(PWM_REGS), .N_QE(N_QE), .QE_REGS(QE_REGS),
        .N_RC(N_RC), .RC_REGS(RC_REGS), .VER_MAJOR(1), .VER_MINOR(2), .SYNC_STAGES(2)
    ) i_hbus_reg_slave (.*);

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
        end
    endtask

    task automatic wait_hs2(input logic lvl, input string tag);
        int n = 0;
        while (blk_hs2 !== lvl && n < 300) begin
            @(negedge clk);
            n++;
        end
        chk(blk_hs2 === lvl, tag, 32'(blk_hs2), 32'(lvl));
    endtask

    task automatic put_byte(input logic [7:0] b);
        host_rw = 1'b1;
        host_data_in = b;
        @(negedge clk);
        host_hs1 = 1'b1;
        wait_hs2(1'b1, "R3");
        host_hs1 = 1'b0;
        wait_hs2(1'b0, "R4");
    endtask

    task automatic get_byte(output logic [7:0] b);
        host_rw = 1'b0;
        @(negedge clk);
        host_hs1 = 1'b1;
        wait_hs2(1'b1, "R3");
        chk(blk_data_oe === 1'b1, "R12", 32'(blk_data_oe), 32'd1);
        b = blk_data_out;
        host_hs1 = 1'b0;
        wait_hs2(1'b0, "R4");
    endtask

    task automatic begin_txn();
        host_start = 1'b1;
        repeat (4) @(negedge clk);
        chk(blk_ack === 1'b1, "R10", 32'(blk_ack), 32'd1);
    endtask

    task automatic finish_txn(output logic [31:0] w0, output logic [31:0] w1);
        logic [7:0] b;
        for (int i = 0; i < 8; i++) begin
            get_byte(b);
            if (i < 4) w0[8*i +: 8] = b;
            else       w1[8*(i-4) +: 8] = b;
        end
        chk(blk_ack === 1'b0, "R10", 32'(blk_ack), 32'd0);
        host_start = 1'b0;
        host_rw = 1'b1;
        repeat (5) @(negedge clk);
    endtask

    task automatic txn(input logic [7:0] op, input logic [7:0] a, input logic [31:0] d,
                       output logic [31:0] w0, output logic [31:0] w1);
        begin_txn();
        put_byte(op);
        put_byte(a);
        for (int i = 0; i < 4; i++) put_byte(d[8*i +: 8]);
        finish_txn(w0, w1);
    endtask

    function automatic logic [7:0] exp_status(input logic [7:0] op, input logic [7:0] a);
        if (op != 8'h01 && op != 8'h02) return 8'd1;
        if (32'(a) >= 32'(END_ADDR)) return 8'd2;
        if (op == 8'h02 && a == 8'd0) return 8'd3;
        return 8'd0;
    endfunction

    function automatic logic [31:0] exp_word0(input logic [7:0] op, input logic [7:0] a);
        if (exp_status(op, a) != 8'd0 || op != 8'h01) return 32'd0;
        return (a == 8'd0) ? SYS_WORD : model[a];
    endfunction

    function automatic string tag_of(input logic [7:0] op, input logic [7:0] a);
        case (exp_status(op, a))
            8'd1: return "R9";
            8'd2: return "R8";
            8'd3: return "R7";
            default: return (a == 8'd0) ? "R7" : (op == 8'h02) ? "R5" : "R6";
        endcase
    endfunction

    task automatic run_check(input logic [7:0] op, input logic [7:0] a, input logic [31:0] d);
        logic [31:0] w0, w1, e0, e1;
        string tag;
        e0 = exp_word0(op, a);
        e1 = 32'(exp_status(op, a));
        tag = tag_of(op, a);
        txn(op, a, d, w0, w1);
        chk(w0 === e0, tag, w0, e0);
        chk(w1 === e1, tag, w1, e1);
        if (e1 == 32'd0 && op == 8'h02) model[a] = d;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : stimulus
        logic [31:0] w0, w1;
        logic [7:0]  op, a;
        void'($urandom(32'd7741));
        for (int i = 0; i < 256; i++) model[i] = 32'd0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);

        // R1 reset state at the ports and in the registers
        chk(blk_hs2 === 1'b0, "R1", 32'(blk_hs2), 32'd0);
        chk(blk_ack === 1'b0, "R1", 32'(blk_ack), 32'd0);
        chk(blk_data_oe === 1'b0, "R1", 32'(blk_data_oe), 32'd0);
        txn(8'h01, 8'd5, 32'd0, w0, w1);
        chk(w0 === 32'd0, "R1", w0, 32'd0);

        // R7 description word and its write protection
        run_check(8'h01, 8'd0, 32'd0);
        run_check(8'h02, 8'd0, 32'hDEAD_BEEF);
        run_check(8'h01, 8'd0, 32'd0);

        // R8 group bases and the edges of the map
        run_check(8'h02, 8'd1, 32'h1111_0001);
        run_check(8'h02, 8'd17, 32'h2222_0017);
        run_check(8'h02, 8'd25, 32'h3333_0025);
        run_check(8'h02, 8'd32, 32'h4444_0032);
        run_check(8'h01, 8'd1, 32'd0);
        run_check(8'h01, 8'd17, 32'd0);
        run_check(8'h01, 8'd25, 32'd0);
        run_check(8'h01, 8'd32, 32'd0);
        run_check(8'h02, 8'd33, 32'h5555_5555);
        run_check(8'h01, 8'd33, 32'd0);
        run_check(8'h02, 8'd255, 32'h6666_6666);

        // R9 unknown opcode leaves the register alone
        run_check(8'h7F, 8'd1, 32'h0BAD_0BAD);
        run_check(8'h00, 8'd1, 32'h0BAD_0BAD);
        run_check(8'h01, 8'd1, 32'd0);

        // R4 hs2 held while hs1 held; R12 no drive during command bytes
        begin_txn();
        host_rw = 1'b1;
        host_data_in = 8'h01;
        @(negedge clk);
        host_hs1 = 1'b1;
        wait_hs2(1'b1, "R3");
        chk(blk_data_oe === 1'b0, "R12", 32'(blk_data_oe), 32'd0);
        repeat (10) @(negedge clk);
        chk(blk_hs2 === 1'b1, "R4", 32'(blk_hs2), 32'd1);
        host_hs1 = 1'b0;
        wait_hs2(1'b0, "R4");
        put_byte(8'd0);
        for (int i = 0; i < 4; i++) put_byte(8'd0);
        finish_txn(w0, w1);
        chk(w0 === SYS_WORD, "R7", w0, SYS_WORD);

        // R11 start dropped in the middle of a write
        begin_txn();
        put_byte(8'h02);
        put_byte(8'd2);
        put_byte(8'hAB);
        host_start = 1'b0;
        repeat (6) @(negedge clk);
        chk(blk_ack === 1'b0, "R11", 32'(blk_ack), 32'd0);
        chk(blk_hs2 === 1'b0, "R11", 32'(blk_hs2), 32'd0);
        txn(8'h01, 8'd2, 32'd0, w0, w1);
        chk(w0 === model[2], "R11", w0, model[2]);
        chk(w1 === 32'd0, "R11", w1, 32'd0);

        // R2 host reset pulse clears the registers
        host_rst_n = 1'b0;
        repeat (20) @(negedge clk);
        host_rst_n = 1'b1;
        repeat (6) @(negedge clk);
        for (int i = 0; i < 256; i++) model[i] = 32'd0;
        chk(blk_ack === 1'b0, "R2", 32'(blk_ack), 32'd0);
        txn(8'h01, 8'd17, 32'd0, w0, w1);
        chk(w0 === 32'd0, "R2", w0, 32'd0);

        // Random mix of reads, writes and stray opcodes
        for (int n = 0; n < 80; n++) begin
            int r;
            r = int'($urandom % 16);
            op = (r < 7) ? 8'h01 : (r < 14) ? 8'h02 : 8'($urandom % 256);
            a = ($urandom % 4 == 0) ? 8'($urandom % 256) : 8'($urandom % 36);
            run_check(op, a, $urandom);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule